// File: doc/BRIEF.md
# Elevator Motor and Call Controller

This block decides where the cabin goes and drives the stepper motor that moves it. Cabin buttons and hall buttons arrive as two one-hot-per-floor vectors. While the controller is idle, a press latches a single target floor. The controller then compares that target with the floor reported by a separate floor tracker. It either runs the motor up or down, or it goes straight to the display phase when the cabin is already at the target. When the tracker reports that the cabin is at the target, the motor stops and the floor digit blinks for a fixed number of one-second periods. After that the controller returns to idle.

Motor speed is not computed here. The step clock is a tap of a free-running counter, passed through to the motor only while the cabin moves. A second counter tap, pulsing once every half second, times the blink phase. The status code is exported so that the floor tracker knows whether the cabin is moving and in which direction. All pins are plain level or strobe signals. No stream data passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `lift_motor_ctrl`

## Requirements
- R1: `motor[0]` is the direction bit. It is 1 while the status is moving down and 0 in every other status.
- R2: While moving, `motor[1]` equals `step_tap`. In idle and blink it is 0.
- R3: `sleep` is 1 only while moving up or moving down. It is 0 in idle and during blinking.
- R4: `status` encodes idle as 0, moving up as 1, moving down as 2 and blinking as 3. After reset it is 0.
- R5: While moving, the controller enters blinking on the clock edge where `at_floor` is 1 and `cur_floor` equals the latched target. With `at_floor` at 0 it keeps moving, even when `cur_floor` equals the target.
- R6: `seg` carries segments a..g on bits 6..0 and is active high. The digits are 0=7E, 1=30, 2=6D, 3=79 and 4=33 in hex. Floor values of 10 and above give all zeros.
- R7: In idle, the two button vectors are ORed. The lowest set index becomes the target on the next edge. Presses in any other status are ignored and leave the target unchanged.
- R8: A target above `cur_floor` starts moving up. A target below it starts moving down. A target equal to it goes straight to blinking.
- R9: Blinking counts `half_sec_tick` pulses. The digit is shown before the first pulse and after every even count, and `seg` is 0 after every odd count. The edge carrying the tenth pulse (2×BLINKS) returns the status to idle.
- R10: An `at_floor` report at a floor other than the target does not stop the motor.
- R11: Outside blinking, `seg` shows the digit of `cur_floor` steadily.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cabin_btn | input | 5 | Buttons inside the cabin, one bit per floor |
| hall_btn | input | 5 | Hall buttons, one bit per floor |
| cur_floor | input | 3 | Floor held by the floor tracker |
| at_floor | input | 1 | The cabin is aligned with `cur_floor` |
| step_tap | input | 1 | Counter bit used as the motor step clock |
| half_sec_tick | input | 1 | One-cycle strobe every half second |
| motor | output | 2 | Bit 1 is the step clock, bit 0 is the direction (1 = down) |
| sleep | output | 1 | Motor enable, 1 = on |
| seg | output | 7 | Segments abcdefg, active high |
| status | output | 2 | 0 idle, 1 up, 2 down, 3 blinking |

## Verification
The hardest case to reach from the ports is a press that arrives while the cabin is already busy. A busy-time press has no visible effect at the moment it happens. Its absence can only be seen later, at the floor where the cabin actually stops. The bench presses a lower button mid-trip, then reports arrivals at the floor of the stray press and at the floor the target encoder would have chosen. It checks that the cabin halts only at the floor originally latched. The bench also reports `cur_floor` equal to the target with `at_floor` low, to show that position alone does not end a trip.

// File: rtl/lift_pkg.sv
package lift_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UP    = 2'd1,
    ST_DOWN  = 2'd2,
    ST_BLINK = 2'd3
  } lift_state_e;
endpackage

// File: rtl/lift_call_pick.sv
module lift_call_pick #(
  parameter int FLOORS = 5,
  localparam int FW = $clog2(FLOORS)
) (
  input  logic [FLOORS-1:0] req,
  output logic              valid,
  output logic [FW-1:0]     idx
);
  // Scan from the top down so the lowest set bit is written last.
  always_comb begin
    idx = '0;
    for (int i = FLOORS - 1; i >= 0; i--) begin
      if (req[i]) idx = FW'(i);
    end
  end
  assign valid = |req;
endmodule

// File: rtl/lift_seg_dec.sv
module lift_seg_dec #(
  parameter int FW = 3
) (
  input  logic [FW-1:0] digit,
  output logic [6:0]    seg
);
  // bit 6 = a ... bit 0 = g, active high
  always_comb begin
    case (32'(digit))
      0:       seg = 7'b1111110;
      1:       seg = 7'b0110000;
      2:       seg = 7'b1101101;
      3:       seg = 7'b1111001;
      4:       seg = 7'b0110011;
      5:       seg = 7'b1011011;
      6:       seg = 7'b1011111;
      7:       seg = 7'b1110000;
      8:       seg = 7'b1111111;
      9:       seg = 7'b1111011;
      default: seg = 7'b0000000;
    endcase
  end
endmodule

// File: rtl/lift_blink_timer.sv
module lift_blink_timer #(
  parameter int BLINKS = 5,
  localparam int HALVES = 2 * BLINKS,
  localparam int CW = $clog2(HALVES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic tick,
  output logic lit,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= '0;
    else if (active && tick)  cnt_q <= cnt_q + 1'b1;
  end

  assign lit  = ~cnt_q[0];
  assign done = active && tick && (cnt_q == CW'(HALVES - 1));
endmodule

// File: rtl/lift_motor_ctrl.sv
module lift_motor_ctrl #(
  parameter int FLOORS = 5,
  parameter int BLINKS = 5,
  localparam int FW = $clog2(FLOORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLOORS-1:0] cabin_btn,
  input  logic [FLOORS-1:0] hall_btn,
  input  logic [FW-1:0]     cur_floor,
  input  logic              at_floor,
  input  logic              step_tap,
  input  logic              half_sec_tick,
  output logic [1:0]        motor,
  output logic              sleep,
  output logic [6:0]        seg,
  output logic [1:0]        status
);
  import lift_pkg::*;

  lift_state_e   state_q, state_d;
  logic [FW-1:0] target_q;
  logic          pick_valid;
  logic [FW-1:0] pick_idx;
  logic          blink_lit, blink_done, enter_blink;
  logic [6:0]    digit_seg;
  logic          moving;

  lift_call_pick #(.FLOORS(FLOORS)) u_pick (
    .req   (cabin_btn | hall_btn),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (pick_valid) begin
        if (pick_idx > cur_floor)      state_d = ST_UP;
        else if (pick_idx < cur_floor) state_d = ST_DOWN;
        else                           state_d = ST_BLINK;
      end
      ST_UP, ST_DOWN:
        if (at_floor && cur_floor == target_q) state_d = ST_BLINK;
      ST_BLINK: if (blink_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign enter_blink = (state_q != ST_BLINK) && (state_d == ST_BLINK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && pick_valid) target_q <= pick_idx;
    end
  end

  lift_blink_timer #(.BLINKS(BLINKS)) u_blink (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (enter_blink),
    .active (state_q == ST_BLINK),
    .tick   (half_sec_tick),
    .lit    (blink_lit),
    .done   (blink_done)
  );

  lift_seg_dec #(.FW(FW)) u_dec (
    .digit (cur_floor),
    .seg   (digit_seg)
  );

  assign moving = (state_q == ST_UP) || (state_q == ST_DOWN);
  assign sleep  = moving;
  assign motor  = {moving & step_tap, state_q == ST_DOWN};
  assign seg    = (state_q == ST_BLINK && !blink_lit) ? 7'b0 : digit_seg;
  assign status = state_q;
endmodule

// File: rtl/lift_motor_ctrl_chk.sv
module lift_motor_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] motor,
  input logic       sleep,
  input logic [1:0] status,
  input logic       at_floor,
  input logic       step_tap
);
  AST_IDLE_MOTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd0 |-> !sleep && motor == 2'b00); // R3
  AST_BLINK_MOTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd3 |-> !sleep && motor == 2'b00); // R3
  AST_DOWN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd2 |-> motor[0] && sleep); // R1
  AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd1 |-> !motor[0] && sleep); // R1
  AST_STEP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> motor[1] == step_tap); // R2
  AST_STOP_NEEDS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 || status == 2'd2) && !at_floor |=> status != 2'd3); // R5
  AST_BLINK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd3 |=> status == 2'd3 || status == 2'd0); // R9
  AST_NO_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd1 |=> status != 2'd2); // R8
endmodule

bind lift_motor_ctrl lift_motor_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .motor    (motor),
  .sleep    (sleep),
  .status   (status),
  .at_floor (at_floor),
  .step_tap (step_tap)
);

// File: tb/lift_motor_ctrl_bench.sv
`timescale 1ns/1ps
module lift_motor_ctrl_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] cabin_btn = 0, hall_btn = 0;
  logic [2:0] cur_floor = 0;
  logic       at_floor = 0, step_tap = 0, half_sec_tick = 0;
  logic [1:0] motor, status;
  logic       sleep;
  logic [6:0] seg;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lift_motor_ctrl u_lift_motor_ctrl (
    .clk(clk), .rst_n(rst_n), .cabin_btn(cabin_btn), .hall_btn(hall_btn),
    .cur_floor(cur_floor), .at_floor(at_floor), .step_tap(step_tap),
    .half_sec_tick(half_sec_tick), .motor(motor), .sleep(sleep),
    .seg(seg), .status(status)
  );

  function automatic logic [6:0] dig(input int f);
    case (f)
      0: return 7'h7E; 1: return 7'h30; 2: return 7'h6D;
      3: return 7'h79; 4: return 7'h33; default: return 7'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic press(input logic [4:0] c, input logic [4:0] h);
    cabin_btn = c; hall_btn = h;
    step();
    cabin_btn = 0; hall_btn = 0;
  endtask

  task automatic arrive(input int f, input logic af);
    cur_floor = 3'(f); at_floor = af;
    step();
    at_floor = 0;
  endtask

  task automatic run_blink(input int f);
    for (int i = 0; i < 10; i++) begin
      chk("R9 blink status", status, 3);
      chk("R9 blink seg", seg, (i % 2 == 0) ? dig(f) : 0);
      half_sec_tick = 1; step(); half_sec_tick = 0;
    end
    chk("R9 idle after 10 ticks", status, 0);
    chk("R11 steady digit", seg, dig(f));
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step();
    chk("R4 reset status", status, 0);
    chk("R3 reset sleep", sleep, 0);
    chk("R2 reset motor", motor, 0);
    chk("R6 digit 0", seg, 7'h7E);
    rst_n = 1; step();
  endtask

  task automatic t_up_trip();
    press(5'b01000, 0);
    chk("R8 up", status, 1);
    chk("R1 up dir", motor[0], 0);
    chk("R3 sleep up", sleep, 1);
    step_tap = 1; #1 chk("R2 step high", motor[1], 1);
    step_tap = 0; #1 chk("R2 step low", motor[1], 0);
    step();
    arrive(1, 1);
    chk("R10 pass floor 1", status, 1);
    chk("R11 digit 1 moving", seg, 7'h30);
    arrive(3, 0);
    chk("R5 no at_floor", status, 1);
    arrive(3, 1);
    chk("R5 stop at 3", status, 3);
    chk("R3 sleep off blink", sleep, 0);
    press(5'b00001, 0);
    chk("R7 ignored in blink", status, 3);
    run_blink(3);
  endtask

  task automatic t_down_trip();
    press(0, 5'b00010);
    chk("R8 down", status, 2);
    chk("R1 down dir", motor[0], 1);
    arrive(1, 1);
    chk("R5 stop at 1", status, 3);
    run_blink(1);
  endtask

  task automatic t_same_floor();
    press(5'b00010, 0);
    chk("R8 same floor blink", status, 3);
    chk("R2 motor off", motor, 0);
    run_blink(1);
  endtask

  task automatic t_priority();
    press(5'b10000, 5'b00100);
    chk("R7 lowest index up", status, 1);
    press(5'b00001, 0);
    chk("R7 busy press ignored", status, 1);
    arrive(0, 1);
    chk("R7 no stop at stray 0", status, 1);
    arrive(4, 1);
    chk("R10 no stop at 4", status, 1);
    chk("R6 digit 4", seg, 7'h33);
    arrive(2, 1);
    chk("R7 stop at 2", status, 3);
    chk("R6 digit 2", seg, 7'h6D);
    run_blink(2);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_up_trip();
    t_down_trip();
    t_same_floor();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule